// File: doc/BRIEF.md
# Write-Once Watchdog Timer with Keyed Service

The block is a system watchdog for an embedded controller. Firmware programs one control word holding a reload count, a prescale selection, a debug-freeze selection, an enable bit and the choice between a reset request and an interrupt on expiry. The control word is accepted only by the first write after power-on reset. Every later write is discarded, so firmware reads the word back to learn whether its setting took effect. Once running, the watchdog cannot be stopped. If the first write left it disabled, it can never be started.

While enabled, a down-counter counts once per clock, or once per prescale period. It is restarted only when the two service keys are written in the correct order. If it runs out, the block raises a level interrupt or emits a one-cycle reset request. In reset mode it also sets a sticky cause flag that firmware clears by writing one. The register port is a simple word-addressed read/write port with one cycle of read latency. Input `rst` is the power-on reset of the block itself. The system reset that the block requests does not reset the block.

Top module: `svc_watchdog`

## Requirements
- R1: After `rst`, the control, count and cause registers read 0, and `wdt_irq` and `wdt_rst_req` are low. A read strobed on one clock edge returns data on `bus_rdata` after that edge. Offset 0x0 is the cause word (bit 0), 0x4 is control, 0x8 is count and 0xC is service.
- R2: The control word holds the reload count in bits 31:16, freeze in bit 3, enable in bit 2, mode select in bit 1 and prescale in bit 0. Its first write stores these bits, and they read back unchanged. A first write with enable 1 loads the counter with the reload count on the same edge.
- R3: Every control write after the first is ignored, whether the first write enabled or disabled the watchdog. The control word and a running count are left unchanged.
- R4: With prescale 0, an enabled counter steps down by one on every clock. A step taken at count 0 is an expiry and reloads the reload count, so expiries come every reload+1 clocks.
- R5: With prescale 1, the counter steps once every PRESCALE_DIV clocks. The prescale phase restarts at every counter load.
- R6: With mode select 1, an expiry gives a one-cycle `wdt_rst_req` pulse and sets the cause flag, and `wdt_irq` stays low. With mode select 0, an expiry sets `wdt_irq`, which stays high.
- R7: A service write of 16'h556C followed by a service write of 16'hAA39 reloads the counter, restarts the prescale phase and clears `wdt_irq`. Service data is taken from `bus_wdata[15:0]`.
- R8: A service write that is not the expected next key makes the checker wait for 16'h556C again and does not reload the counter. This covers a wrong value, 16'hAA39 alone, and 16'h556C written twice.
- R9: Between the two keys, any number of idle cycles and any accesses to other registers leave the sequence intact.
- R10: While freeze is 1 and `dbg_halt` is high, the counter and the prescaler hold. With freeze 0, `dbg_halt` has no effect.
- R11: Writing 1 to bit 0 of the cause word clears the cause flag. Writing 0 leaves it unchanged, and an expiry on the same edge wins over the clear.
- R12: Writes to the count register are ignored.
- R13: A disabled watchdog never counts and never raises `wdt_irq` or `wdt_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debugger halt indication |
| wdt_irq | output | 1 | Expiry interrupt, level, cleared by service |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
A lost lock shows at the next control write: the read-back word changes, and a running count jumps or stops, on the edge after the write. A checker stuck in the wrong key state shows in the count read on the cycle after the second key. That read returns exactly the reload value only when a reload really took place. A wrong down-counter or prescaler phase moves the expiry edge, so `wdt_irq` or `wdt_rst_req` appears one or more clocks early or late at the predicted cycle. A wrong freeze gate shows as a count that changes between two reads taken while halted.

// File: rtl/svc_watchdog_pkg.sv
package svc_watchdog_pkg;

  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hAA39;

  localparam int BIT_PRE = 0;
  localparam int BIT_SEL = 1;
  localparam int BIT_EN  = 2;
  localparam int BIT_FRZ = 3;

  localparam logic [3:0] OFS_CAUSE   = 4'h0;
  localparam logic [3:0] OFS_CTRL    = 4'h4;
  localparam logic [3:0] OFS_COUNT   = 4'h8;
  localparam logic [3:0] OFS_SERVICE = 4'hC;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_t;

endpackage

// File: rtl/svc_watchdog_prescaler.sv
module svc_watchdog_prescaler #(
  parameter int PRESCALE_DIV = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic use_div,
  input  logic clear,
  output logic tick
);
  localparam int PS_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE_DIV - 1);

  logic [PS_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
    end else if (clear) begin
      pcnt_q <= '0;
    end else if (run && use_div) begin
      pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
    end
  end

  assign tick = run && (!use_div || (pcnt_q == LAST));

  // R10: a halted prescaler keeps its phase
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(pcnt_q));

  // R5: a load always restarts the phase
  assert_phase_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pcnt_q == '0));

endmodule

// File: rtl/svc_watchdog_keyseq.sv
module svc_watchdog_keyseq
  import svc_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_wr,
  input  logic [KEY_W-1:0] svc_data,
  output logic             svc_ok
);
  seq_state_t state_q;

  assign svc_ok = svc_wr && (state_q == SEQ_ARMED) && (svc_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else if (svc_wr) begin
      if ((state_q == SEQ_IDLE) && (svc_data == KEY_FIRST)) begin
        state_q <= SEQ_ARMED;
      end else begin
        state_q <= SEQ_IDLE;
      end
    end
  end

  // R8: any service write other than the first key leaves the checker waiting for it
  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && (svc_data != KEY_FIRST)) |=> (state_q == SEQ_IDLE));

  // R9: the armed state survives cycles without a service write
  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (!svc_wr && (state_q == SEQ_ARMED)) |=> (state_q == SEQ_ARMED));

endmodule

// File: rtl/svc_watchdog_counter.sv
module svc_watchdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;

  assign count  = count_q;
  assign expire = tick && !load && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick) begin
      count_q <= (count_q == '0) ? load_val : count_q - 1'b1;
    end
  end

  // R4: a step above zero takes exactly one off the count
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

  // R4: an expiry is followed by the reload value
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count_q == $past(load_val)));

  // R10: without a tick or load the count holds
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(count_q));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_watchdog_pkg::*;
#(
  parameter int PRESCALE_DIV = 65536,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  localparam int LOW_W = DATA_W - CNT_W;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    {{CNT_W{1'b1}}, {(LOW_W-4){1'b0}}, 4'hF};

  logic [DATA_W-1:0] ctrl_q;
  logic              locked_q;
  logic              cause_q;
  logic              irq_q;
  logic              rst_req_q;
  logic [DATA_W-1:0] rdata_q;

  logic              wr_ctrl, wr_cause, wr_svc, ctrl_take;
  logic              enabled, svc_ok, cnt_load, tick, expire, run;
  logic [CNT_W-1:0]  reload_val, count;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_cause = bus_wr && (bus_addr == OFS_CAUSE);
  assign wr_svc   = bus_wr && (bus_addr == OFS_SERVICE);

  assign ctrl_take  = wr_ctrl && !locked_q;
  assign enabled    = ctrl_q[BIT_EN];
  assign reload_val = ctrl_take ? bus_wdata[DATA_W-1 -: CNT_W]
                                : ctrl_q[DATA_W-1 -: CNT_W];
  assign cnt_load   = (ctrl_take && bus_wdata[BIT_EN]) || (svc_ok && enabled);
  assign run        = enabled && !(ctrl_q[BIT_FRZ] && dbg_halt);

  // control word: accepted once after power-on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (ctrl_take) begin
      ctrl_q   <= bus_wdata & CTRL_MASK;
      locked_q <= 1'b1;
    end
  end

  svc_watchdog_keyseq u_keyseq (
    .clk      (clk),
    .rst      (rst),
    .svc_wr   (wr_svc),
    .svc_data (bus_wdata[KEY_W-1:0]),
    .svc_ok   (svc_ok)
  );

  svc_watchdog_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_prescaler (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .use_div (ctrl_q[BIT_PRE]),
    .clear   (cnt_load),
    .tick    (tick)
  );

  svc_watchdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (reload_val),
    .tick     (tick),
    .count    (count),
    .expire   (expire)
  );

  // expiry outputs and cause flag
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      cause_q   <= 1'b0;
    end else begin
      rst_req_q <= expire && ctrl_q[BIT_SEL];
      if (expire && !ctrl_q[BIT_SEL]) begin
        irq_q <= 1'b1;
      end else if (svc_ok) begin
        irq_q <= 1'b0;
      end
      if (expire && ctrl_q[BIT_SEL]) begin
        cause_q <= 1'b1;
      end else if (wr_cause && bus_wdata[0]) begin
        cause_q <= 1'b0;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CAUSE: rdata_q <= {{(DATA_W-1){1'b0}}, cause_q};
        OFS_CTRL:  rdata_q <= ctrl_q;
        OFS_COUNT: rdata_q <= {{LOW_W{1'b0}}, count};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata   = rdata_q;
  assign wdt_irq     = irq_q;
  assign wdt_rst_req = rst_req_q;

  // R3: a locked control word does not move on a write
  assert_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_ctrl) |=> $stable(ctrl_q));

  // R6: the two expiry outputs never coincide
  assert_mode_R6: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && rst_req_q));

  // R6: a reset request is always recorded in the cause flag
  assert_cause_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> cause_q);

  // R7: a completed key pair leaves the interrupt low
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    svc_ok |=> !irq_q);

  // R13: a disabled watchdog raises nothing
  assert_disabled_R13: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (!irq_q && !rst_req_q));

endmodule

// File: tb/svc_watchdog_test.sv
module svc_watchdog_test;

  localparam int DIV = 2048;
  localparam logic [15:0] K1 = 16'h556C;
  localparam logic [15:0] K2 = 16'hAA39;
  localparam logic [15:0] NTBL = 16'd1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        wdt_irq;
  logic        wdt_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  svc_watchdog #(.PRESCALE_DIV(DIV), .CNT_W(16)) uut (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dbg_halt    (dbg_halt),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req)
  );

  // service stimulus: {expect reload, key}
  localparam logic [16:0] SVC_TBL [0:13] = '{
    {1'b0, K1}, {1'b1, K2},
    {1'b0, 16'h1234}, {1'b0, K2},
    {1'b0, K1}, {1'b0, K1}, {1'b0, K2},
    {1'b0, K2}, {1'b0, K1}, {1'b1, K2},
    {1'b0, K1}, {1'b0, 16'h556D}, {1'b0, K2},
    {1'b0, K2}
  };

  function automatic logic [31:0] cfg(input logic [15:0] tc, input logic frz,
                                      input logic en, input logic sel, input logic pre);
    return {tc, 12'h000, frz, en, sel, pre};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; dbg_halt = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    rdreg(4'h4, rd); chk("R1 ctrl", rd, 32'h0);
    rdreg(4'h8, rd); chk("R1 count", rd, 32'h0);
    rdreg(4'h0, rd); chk("R1 cause", rd, 32'h0);
    chk("R1 irq", {31'h0, wdt_irq}, 32'h0);
    chk("R1 rst_req", {31'h0, wdt_rst_req}, 32'h0);

    // R8 R7 R9: service table, free-running count from NTBL
    wr(4'h4, cfg(NTBL, 1'b0, 1'b1, 1'b0, 1'b0));
    idle(3);
    for (int i = 0; i < 14; i++) begin
      wr(4'hC, {16'h0, SVC_TBL[i][15:0]});
      rdreg(4'h8, rd);
      if (SVC_TBL[i][16]) chk($sformatf("R7 reload entry %0d", i), rd, {16'h0, NTBL});
      else chk($sformatf("R8 no reload entry %0d", i), {31'h0, rd < {16'h0, NTBL}}, 32'h1);
    end
    // R9 gap and other accesses between keys
    wr(4'hC, {16'h0, K1});
    wr(4'h0, 32'h0);
    rdreg(4'h4, rd);
    wr(4'h8, 32'h0);
    idle(30);
    wr(4'hC, {16'h0, K2});
    rdreg(4'h8, rd); chk("R9 reload after gap", rd, {16'h0, NTBL});

    // R2 R4 countdown without prescale, interrupt mode
    do_reset();
    wr(4'h4, cfg(16'd5, 1'b0, 1'b1, 1'b0, 1'b0));
    rdreg(4'h8, rd); chk("R2 load on enable", rd, 32'd5);
    rdreg(4'h8, rd); chk("R4 step", rd, 32'd4);
    idle(3); chk("R4 before expiry", {31'h0, wdt_irq}, 32'h0);
    idle(1); chk("R6 irq on expiry", {31'h0, wdt_irq}, 32'h1);
    chk("R6 no rst_req in irq mode", {31'h0, wdt_rst_req}, 32'h0);
    rdreg(4'h8, rd); chk("R4 reload on expiry", rd, 32'd5);
    rdreg(4'h4, rd); chk("R2 readback", rd, cfg(16'd5, 1'b0, 1'b1, 1'b0, 1'b0));
    idle(10); chk("R6 irq stays", {31'h0, wdt_irq}, 32'h1);

    // R5 prescale, then R7 irq clear
    do_reset();
    wr(4'h4, cfg(16'd1, 1'b0, 1'b1, 1'b0, 1'b1));
    idle(2047);
    rdreg(4'h8, rd); chk("R5 count before first step", rd, 32'd1);
    rdreg(4'h8, rd); chk("R5 count after first step", rd, 32'd0);
    idle(2046); chk("R5 no early expiry", {31'h0, wdt_irq}, 32'h0);
    idle(1); chk("R5 expiry after two periods", {31'h0, wdt_irq}, 32'h1);
    wr(4'hC, {16'h0, K1});
    wr(4'hC, {16'h0, K2});
    chk("R7 irq cleared", {31'h0, wdt_irq}, 32'h0);
    rdreg(4'h8, rd); chk("R7 reload in prescale mode", rd, 32'd1);

    // R6 reset mode, R10 freeze, R11 cause clear
    do_reset();
    wr(4'h4, cfg(16'd3, 1'b1, 1'b1, 1'b1, 1'b0));
    idle(3); chk("R6 no early rst_req", {31'h0, wdt_rst_req}, 32'h0);
    idle(1); chk("R6 rst_req pulse", {31'h0, wdt_rst_req}, 32'h1);
    chk("R6 irq low in reset mode", {31'h0, wdt_irq}, 32'h0);
    idle(1); chk("R6 rst_req one cycle", {31'h0, wdt_rst_req}, 32'h0);
    rdreg(4'h0, rd); chk("R6 cause set", rd, 32'h1);
    dbg_halt = 1'b1;
    rdreg(4'h8, rd); chk("R10 frozen count", rd, 32'd1);
    idle(20);
    rdreg(4'h8, rd); chk("R10 count held", rd, 32'd1);
    wr(4'h0, 32'h0);
    rdreg(4'h0, rd); chk("R11 write 0 keeps cause", rd, 32'h1);
    wr(4'h0, 32'h1);
    rdreg(4'h0, rd); chk("R11 write 1 clears cause", rd, 32'h0);
    idle(20);
    rdreg(4'h0, rd); chk("R10 no expiry while frozen", rd, 32'h0);
    dbg_halt = 1'b0;
    idle(10);
    rdreg(4'h0, rd); chk("R10 resumes after halt", rd, 32'h1);

    // R10 halt without freeze has no effect
    do_reset();
    dbg_halt = 1'b1;
    wr(4'h4, cfg(16'd50, 1'b0, 1'b1, 1'b0, 1'b0));
    rdreg(4'h8, rd); chk("R10 load", rd, 32'd50);
    idle(9);
    rdreg(4'h8, rd); chk("R10 counts without freeze", rd, 32'd40);
    dbg_halt = 1'b0;

    // R3 lock after enabling, R12 count write ignored
    do_reset();
    wr(4'h4, cfg(16'd50, 1'b0, 1'b1, 1'b0, 1'b0));
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0000FFFF);
    rdreg(4'h8, rd); chk("R12 count write ignored", rd, 32'd48);
    rdreg(4'h4, rd); chk("R3 ctrl kept after enable", rd, cfg(16'd50, 1'b0, 1'b1, 1'b0, 1'b0));

    // R3 R13 lock after disabling
    do_reset();
    wr(4'h4, cfg(16'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(4'h4, cfg(16'd2, 1'b0, 1'b1, 1'b1, 1'b0));
    rdreg(4'h4, rd); chk("R3 enable refused", rd, cfg(16'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(4'hC, {16'h0, K1});
    wr(4'hC, {16'h0, K2});
    idle(20);
    chk("R13 no irq", {31'h0, wdt_irq}, 32'h0);
    chk("R13 no rst_req", {31'h0, wdt_rst_req}, 32'h0);
    rdreg(4'h8, rd); chk("R13 count idle", rd, 32'h0);
    rdreg(4'h0, rd); chk("R13 cause idle", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule